// File: doc/BRIEF.md
# BISYNC Receive Character Filter

This block sits behind a BISYNC receiver that already holds character synchronization. It sees one received character at a time and decides what happens to it. The character may be dropped as line fill, such as a SYNC or an escaping DLE. It may be written into the current receive buffer. It may be passed to the block check logic without being stored.

Each character that is kept is compared against a programmable table of control characters. Every table entry chooses two things for itself. The first is whether the buffer closes on the matched character or only after the trailing block check bytes arrive. The second is whether the receiver drops back to hunting for synchronization once the buffer is closed.

Buffer storage and the CRC/LRC arithmetic belong to neighbouring blocks. These outputs drive them:
- a write strobe with the character;
- a flag that marks the characters belonging in the block check;
- a close pulse;
- an interrupt pulse;
- a hunt request.

While the receiver is hunting, the filter ignores its input until a resync strobe arrives.

Top module: `bisync_rx_filter`

## Requirements
- R1: While reset is held, every output is 0. Hunting is 0 after reset.
- R2: A character received in sync that is not stripped, not part of a block check, and not in the table is written. `wrStrobe` and `bcsInclude` rise in the cycle after `chValid`, with `wrData` equal to the character.
- R3: Outside a block check, when `syncEn` is 1, a character equal to `syncChar` (all 8 bits compared, parity included) is discarded. It produces no write and no `bcsInclude`. When `syncEn` is 0, such a character is data.
- R4: In transparent mode with `dleEn` set, a character equal to `dleChar` is discarded and kept out of the block check. Outside transparent mode, or with `dleEn` clear, it is data.
- R5: The character right after a stripped DLE is handled as follows:
  - If it equals `syncChar`, it is also discarded, regardless of `syncEn`.
  - If it is any other character, including a second DLE, it is data.
- R6: A kept character that matches a table entry whose wait flag is 0 is written. `bufClose` and `irq` pulse in the same cycle as that write.
- R7: A kept character that matches an entry whose wait flag is 1 is written without closing. The following bytes are then treated as block check bytes:
  - There is one such byte when `bcsTwoBytes` is 0 and two when it is 1.
  - Each has `bcsInclude` set and `wrStrobe` clear.
  - `bufClose` and `irq` pulse with the last of them.
- R8: When the matched entry's hunt flag is 1, `huntReq` pulses for one cycle together with the close, and `hunting` rises at that moment. Characters then produce no output until a `resync` pulse clears `hunting`. When the hunt flag is 0, `hunting` stays 0.
- R9: An entry with its valid bit clear never matches. When several valid entries hold the same character, the lowest-indexed entry decides the wait and hunt behaviour.
- R10: A stripped character is never looked up in the table. A SYNC that is also a table entry closes nothing while `syncEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chValid | input | 1 | A received character is present this cycle |
| chData | input | 8 | Received character |
| syncChar | input | 8 | SYNC character value |
| syncEn | input | 1 | Strip SYNC characters |
| dleChar | input | 8 | DLE character value |
| dleEn | input | 1 | Strip DLE characters in transparent mode |
| transpMode | input | 1 | Transparent mode |
| bcsTwoBytes | input | 1 | 1: two-byte CRC check, 0: one-byte LRC check |
| ctlChar | input | 64 | Control table characters, entry i in bits [8i+7:8i] |
| ctlValid | input | 8 | Per-entry valid bit |
| ctlWaitBcs | input | 8 | Per-entry wait for block check before closing |
| ctlHunt | input | 8 | Per-entry hunt after closing |
| resync | input | 1 | Leave hunt mode |
| wrStrobe | output | 1 | Write `wrData` into the receive buffer |
| wrData | output | 8 | Character being written or checked |
| bcsInclude | output | 1 | `wrData` belongs in the block check |
| bufClose | output | 1 | Close the current buffer (pulse) |
| irq | output | 1 | Buffer-closed interrupt (pulse) |
| huntReq | output | 1 | Request to enter hunt mode (pulse) |
| hunting | output | 1 | Filter is in hunt mode and ignoring input |

## Verification
Several properties are checked on every cycle:
- Idle cycles produce no output.
- A stripped SYNC is never written.
- `huntReq` lasts exactly one cycle and coincides with `hunting`.
- Nothing passes through while hunting.

Other behaviour can only be shown by the bench's scenarios compared against its reference model. This covers DLE–SYNC pair stripping, DLE–DLE passing, the one- or two-byte count of block check bytes, table priority among duplicates, invalid entries, and the interplay of SYNC stripping with a table entry holding the SYNC value.

// File: rtl/bisync_filt_pkg.sv
package bisync_filt_pkg;

  // classification of the incoming character, produced by the datapath
  typedef struct packed {
    logic isSync;
    logic isDle;
    logic hit;
    logic hitWait;
    logic hitHunt;
  } charInfo_t;

  // one-cycle actions decided by the control
  typedef struct packed {
    logic write;
    logic bcsOnly;
    logic close;
    logic enterHunt;
  } filtStrobe_t;

endpackage

// File: rtl/bisync_filt_dp.sv
module bisync_filt_dp
  import bisync_filt_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int TABLE_N = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [CHAR_W-1:0]         chData,
  input  logic [CHAR_W-1:0]         syncChar,
  input  logic [CHAR_W-1:0]         dleChar,
  input  logic [TABLE_N*CHAR_W-1:0] ctlChar,
  input  logic [TABLE_N-1:0]        ctlValid,
  input  logic [TABLE_N-1:0]        ctlWaitBcs,
  input  logic [TABLE_N-1:0]        ctlHunt,
  input  filtStrobe_t               strobe,
  output charInfo_t                 info,
  output logic                      wrStrobe,
  output logic [CHAR_W-1:0]         wrData,
  output logic                      bcsInclude,
  output logic                      bufClose,
  output logic                      irq,
  output logic                      huntReq
);

  logic [TABLE_N-1:0] hitVec;

  for (genvar g = 0; g < TABLE_N; g++) begin : gEntry
    assign hitVec[g] = ctlValid[g] && (ctlChar[g*CHAR_W +: CHAR_W] == chData);
  end

  always_comb begin
    info         = '0;
    info.isSync  = (chData == syncChar);
    info.isDle   = (chData == dleChar);
    info.hit     = |hitVec;
    // walk from the top so the lowest matching index wins
    for (int i = TABLE_N - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        info.hitWait = ctlWaitBcs[i];
        info.hitHunt = ctlHunt[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrStrobe   <= 1'b0;
      wrData     <= '0;
      bcsInclude <= 1'b0;
      bufClose   <= 1'b0;
      irq        <= 1'b0;
      huntReq    <= 1'b0;
    end else begin
      wrStrobe   <= strobe.write;
      bcsInclude <= strobe.write | strobe.bcsOnly;
      bufClose   <= strobe.close;
      irq        <= strobe.close;
      huntReq    <= strobe.enterHunt;
      if (strobe.write | strobe.bcsOnly) wrData <= chData;
    end
  end

endmodule

// File: rtl/bisync_filt_ctrl.sv
module bisync_filt_ctrl
  import bisync_filt_pkg::*;
#(
  parameter int BCS_MAX = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        chValid,
  input  logic        resync,
  input  logic        syncEn,
  input  logic        dleEn,
  input  logic        transpMode,
  input  logic        bcsTwoBytes,
  input  charInfo_t   info,
  output filtStrobe_t strobe,
  output logic        hunting
);

  localparam int BCS_W = $clog2(BCS_MAX + 1);

  logic [BCS_W-1:0] bcsLeft;
  logic             dlePend;
  logic             pendHunt;
  logic             setDle, clrDle, loadBcs, stepBcs;

  always_comb begin
    strobe  = '0;
    setDle  = 1'b0;
    clrDle  = 1'b0;
    loadBcs = 1'b0;
    stepBcs = 1'b0;
    if (chValid && !hunting) begin
      if (bcsLeft != '0) begin
        strobe.bcsOnly = 1'b1;
        stepBcs        = 1'b1;
        if (bcsLeft == BCS_W'(1)) begin
          strobe.close     = 1'b1;
          strobe.enterHunt = pendHunt;
        end
      end else if (transpMode && dleEn && info.isDle && !dlePend) begin
        setDle = 1'b1;
      end else if (dlePend && info.isSync) begin
        clrDle = 1'b1;
      end else if (!(syncEn && info.isSync)) begin
        strobe.write = 1'b1;
        clrDle       = 1'b1;
        if (info.hit) begin
          if (info.hitWait) begin
            loadBcs = 1'b1;
          end else begin
            strobe.close     = 1'b1;
            strobe.enterHunt = info.hitHunt;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hunting  <= 1'b0;
      dlePend  <= 1'b0;
      bcsLeft  <= '0;
      pendHunt <= 1'b0;
    end else begin
      if (strobe.enterHunt) hunting <= 1'b1;
      else if (resync)      hunting <= 1'b0;

      if (setDle)                         dlePend <= 1'b1;
      else if (clrDle || strobe.enterHunt) dlePend <= 1'b0;

      if (loadBcs) begin
        bcsLeft  <= bcsTwoBytes ? BCS_W'(2) : BCS_W'(1);
        pendHunt <= info.hitHunt;
      end else if (stepBcs) begin
        bcsLeft  <= bcsLeft - BCS_W'(1);
      end
    end
  end

endmodule

// File: rtl/bisync_rx_filter.sv
module bisync_rx_filter
  import bisync_filt_pkg::*;
#(
  parameter int CHAR_W  = 8,
  parameter int TABLE_N = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      chValid,
  input  logic [CHAR_W-1:0]         chData,
  input  logic [CHAR_W-1:0]         syncChar,
  input  logic                      syncEn,
  input  logic [CHAR_W-1:0]         dleChar,
  input  logic                      dleEn,
  input  logic                      transpMode,
  input  logic                      bcsTwoBytes,
  input  logic [TABLE_N*CHAR_W-1:0] ctlChar,
  input  logic [TABLE_N-1:0]        ctlValid,
  input  logic [TABLE_N-1:0]        ctlWaitBcs,
  input  logic [TABLE_N-1:0]        ctlHunt,
  input  logic                      resync,
  output logic                      wrStrobe,
  output logic [CHAR_W-1:0]         wrData,
  output logic                      bcsInclude,
  output logic                      bufClose,
  output logic                      irq,
  output logic                      huntReq,
  output logic                      hunting
);

  charInfo_t   info;
  filtStrobe_t strobe;

  bisync_filt_dp #(.CHAR_W(CHAR_W), .TABLE_N(TABLE_N)) uDp (
    .clk(clk), .rstN(rstN), .chData(chData), .syncChar(syncChar),
    .dleChar(dleChar), .ctlChar(ctlChar), .ctlValid(ctlValid),
    .ctlWaitBcs(ctlWaitBcs), .ctlHunt(ctlHunt), .strobe(strobe),
    .info(info), .wrStrobe(wrStrobe), .wrData(wrData),
    .bcsInclude(bcsInclude), .bufClose(bufClose), .irq(irq),
    .huntReq(huntReq)
  );

  bisync_filt_ctrl #(.BCS_MAX(2)) uCtrl (
    .clk(clk), .rstN(rstN), .chValid(chValid), .resync(resync),
    .syncEn(syncEn), .dleEn(dleEn), .transpMode(transpMode),
    .bcsTwoBytes(bcsTwoBytes), .info(info), .strobe(strobe),
    .hunting(hunting)
  );

endmodule

// File: rtl/bisync_rx_filter_chk.sv
module bisync_rx_filter_chk #(
  parameter int CHAR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              chValid,
  input logic [CHAR_W-1:0] chData,
  input logic [CHAR_W-1:0] syncChar,
  input logic              syncEn,
  input logic              wrStrobe,
  input logic              bcsInclude,
  input logic              bufClose,
  input logic              huntReq,
  input logic              hunting
);

  // R2: no character presented means nothing comes out
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !chValid |=> (!wrStrobe && !bcsInclude && !bufClose));

  // R3: an enabled SYNC is never written to the buffer
  a_r3_sync_not_written: assert property (@(posedge clk) disable iff (!rstN)
    (chValid && !hunting && syncEn && chData == syncChar) |=> !wrStrobe);

  // R8: hunt request is a single-cycle pulse
  a_r8_hunt_pulse: assert property (@(posedge clk) disable iff (!rstN)
    huntReq |=> !huntReq);

  // R8: hunt request coincides with entering hunt mode
  a_r8_hunt_level: assert property (@(posedge clk) disable iff (!rstN)
    huntReq |-> hunting);

  // R8: input is ignored while hunting
  a_r8_hunt_ignores: assert property (@(posedge clk) disable iff (!rstN)
    (hunting && chValid) |=> (!wrStrobe && !bcsInclude && !bufClose));

endmodule

bind bisync_rx_filter bisync_rx_filter_chk #(.CHAR_W(CHAR_W)) uChk (
  .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData),
  .syncChar(syncChar), .syncEn(syncEn), .wrStrobe(wrStrobe),
  .bcsInclude(bcsInclude), .bufClose(bufClose), .huntReq(huntReq),
  .hunting(hunting)
);

// File: tb/tb_bisync_rx_filter.sv
`timescale 1ns/1ps
module tb_bisync_rx_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        chValid = 1'b0;
  logic [7:0]  chData = 8'h00;
  logic [7:0]  syncChar = 8'h32;
  logic        syncEn = 1'b1;
  logic [7:0]  dleChar = 8'h10;
  logic        dleEn = 1'b1;
  logic        transpMode = 1'b0;
  logic        bcsTwoBytes = 1'b1;
  logic [63:0] ctlChar;
  logic [7:0]  ctlValid, ctlWaitBcs, ctlHunt;
  logic        resync = 1'b0;
  logic        wrStrobe, bcsInclude, bufClose, irq, huntReq, hunting;
  logic [7:0]  wrData;

  logic [7:0] tChar [8];
  bit         tVal [8];
  bit         tWait [8];
  bit         tHunt [8];

  always #2 clk = ~clk;

  always_comb begin
    for (int i = 0; i < 8; i++) begin
      ctlChar[i*8 +: 8] = tChar[i];
      ctlValid[i]       = tVal[i];
      ctlWaitBcs[i]     = tWait[i];
      ctlHunt[i]        = tHunt[i];
    end
  end

  bisync_rx_filter dut (
    .clk(clk), .rstN(rstN), .chValid(chValid), .chData(chData),
    .syncChar(syncChar), .syncEn(syncEn), .dleChar(dleChar), .dleEn(dleEn),
    .transpMode(transpMode), .bcsTwoBytes(bcsTwoBytes), .ctlChar(ctlChar),
    .ctlValid(ctlValid), .ctlWaitBcs(ctlWaitBcs), .ctlHunt(ctlHunt),
    .resync(resync), .wrStrobe(wrStrobe), .wrData(wrData),
    .bcsInclude(bcsInclude), .bufClose(bufClose), .irq(irq),
    .huntReq(huntReq), .hunting(hunting)
  );

  int nChecks = 0, nFails = 0;
  int cntWr = 0, cntBcs = 0, cntClose = 0, cntIrq = 0, cntHunt = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lookup(input logic [7:0] c);
    for (int i = 0; i < 8; i++) if (tVal[i] && tChar[i] == c) return i;
    return -1;
  endfunction

  // behavioural reference model
  bit mHunt, mDle, mPendH;
  int mBcs;
  bit eW, eB, eC, eH;
  logic [7:0] eD;

  always @(posedge clk) begin
    int idx;
    if (!rstN) begin
      mHunt = 0; mDle = 0; mPendH = 0; mBcs = 0;
      eW = 0; eB = 0; eC = 0; eH = 0; eD = 0;
    end else begin
      eW = 0; eB = 0; eC = 0; eH = 0;
      if (mHunt) begin
        if (resync) mHunt = 0;
      end else if (chValid) begin
        if (mBcs > 0) begin
          eB = 1; eD = chData; mBcs--;
          if (mBcs == 0) begin
            eC = 1;
            if (mPendH) begin eH = 1; mHunt = 1; mDle = 0; end
          end
        end else if (transpMode && dleEn && chData == dleChar && !mDle) begin
          mDle = 1;
        end else if (mDle && chData == syncChar) begin
          mDle = 0;
        end else if (syncEn && chData == syncChar) begin
          mDle = mDle;
        end else begin
          eW = 1; eB = 1; eD = chData; mDle = 0;
          idx = lookup(chData);
          if (idx >= 0) begin
            if (tWait[idx]) begin
              mBcs = bcsTwoBytes ? 2 : 1; mPendH = tHunt[idx];
            end else begin
              eC = 1;
              if (tHunt[idx]) begin eH = 1; mHunt = 1; end
            end
          end
        end
      end
      #1;
      chk(wrStrobe == eW, "R2 wrStrobe", wrStrobe, eW);
      if (eB) chk(wrData == eD, "R2 wrData", wrData, eD);
      chk(bcsInclude == eB, "R4 bcsInclude", bcsInclude, eB);
      chk(bufClose == eC, "R6 bufClose", bufClose, eC);
      chk(irq == eC, "R6 irq", irq, eC);
      chk(huntReq == eH, "R8 huntReq", huntReq, eH);
      chk(hunting == mHunt, "R8 hunting", hunting, mHunt);
      cntWr += wrStrobe; cntBcs += bcsInclude; cntClose += bufClose;
      cntIrq += irq; cntHunt += huntReq;
    end
  end

  task automatic clr();
    cntWr = 0; cntBcs = 0; cntClose = 0; cntIrq = 0; cntHunt = 0;
  endtask

  task automatic sendChar(input logic [7:0] c);
    chValid = 1; chData = c;
    @(negedge clk);
    chValid = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic pulseResync();
    resync = 1;
    @(negedge clk);
    resync = 0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finishRun();
  end

  logic [7:0] alpha [9];

  initial begin
    // table: 03 wait/no-hunt, 17 close, 26 close+hunt, 1F wait+hunt,
    // 41 invalid, 17 duplicate with hunt, 32 (= SYNC) close, 7 invalid
    tChar[0] = 8'h03; tVal[0] = 1; tWait[0] = 1; tHunt[0] = 0;
    tChar[1] = 8'h17; tVal[1] = 1; tWait[1] = 0; tHunt[1] = 0;
    tChar[2] = 8'h26; tVal[2] = 1; tWait[2] = 0; tHunt[2] = 1;
    tChar[3] = 8'h1F; tVal[3] = 1; tWait[3] = 1; tHunt[3] = 1;
    tChar[4] = 8'h41; tVal[4] = 0; tWait[4] = 0; tHunt[4] = 0;
    tChar[5] = 8'h17; tVal[5] = 1; tWait[5] = 0; tHunt[5] = 1;
    tChar[6] = 8'h32; tVal[6] = 1; tWait[6] = 0; tHunt[6] = 0;
    tChar[7] = 8'h77; tVal[7] = 0; tWait[7] = 1; tHunt[7] = 1;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk({wrStrobe, bcsInclude, bufClose, irq, huntReq, hunting} == 6'b0,
        "R1 outputs in reset", {wrStrobe, bcsInclude, bufClose, irq, huntReq, hunting}, 0);
    rstN = 1;
    @(negedge clk);
    chk(hunting == 0, "R1 hunting after reset", hunting, 0);

    // R2: plain data
    clr(); sendChar(8'h55); sendChar(8'hAA); sendChar(8'h00); settle();
    chk(cntWr == 3, "R2 plain writes", cntWr, 3);
    chk(cntClose == 0, "R2 no close", cntClose, 0);

    // R3 / R10: SYNC stripping, SYNC in table does not close
    clr(); sendChar(8'h32); sendChar(8'h32); sendChar(8'h44); settle();
    chk(cntWr == 1, "R3 sync stripped", cntWr, 1);
    chk(cntBcs == 1, "R3 sync out of bcs", cntBcs, 1);
    chk(cntClose == 0, "R10 stripped not looked up", cntClose, 0);
    syncEn = 0;
    clr(); sendChar(8'h32); settle();
    chk(cntWr == 1, "R3 sync kept when disabled", cntWr, 1);
    chk(cntClose == 1, "R10 sync matches when kept", cntClose, 1);
    syncEn = 1;

    // R4: DLE stripping
    transpMode = 1;
    clr(); sendChar(8'h10); sendChar(8'h55); settle();
    chk(cntWr == 1, "R4 dle stripped", cntWr, 1);
    chk(cntBcs == 1, "R4 dle out of bcs", cntBcs, 1);
    transpMode = 0;
    clr(); sendChar(8'h10); settle();
    chk(cntWr == 1, "R4 dle data when not transparent", cntWr, 1);
    transpMode = 1; dleEn = 0;
    clr(); sendChar(8'h10); settle();
    chk(cntWr == 1, "R4 dle data when disabled", cntWr, 1);
    dleEn = 1;

    // R5: DLE followed by SYNC / DLE
    syncEn = 0;
    clr(); sendChar(8'h10); sendChar(8'h32); settle();
    chk(cntWr == 0, "R5 dle-sync pair stripped", cntWr, 0);
    chk(cntBcs == 0, "R5 dle-sync out of bcs", cntBcs, 0);
    clr(); sendChar(8'h10); sendChar(8'h10); settle();
    chk(cntWr == 1, "R5 second dle is data", cntWr, 1);
    syncEn = 1; transpMode = 0;

    // R6 / R9: immediate close, lowest duplicate wins
    clr(); sendChar(8'h17); settle();
    chk(cntWr == 1 && cntClose == 1 && cntIrq == 1, "R6 immediate close", cntClose, 1);
    chk(cntHunt == 0 && hunting == 0, "R9 lowest entry wins", cntHunt, 0);

    // R7: block check wait, two bytes then one
    bcsTwoBytes = 1;
    clr(); sendChar(8'h03); sendChar(8'hAB); settle();
    chk(cntClose == 0, "R7 no close before last bcs byte", cntClose, 0);
    sendChar(8'hCD); settle();
    chk(cntWr == 1, "R7 bcs bytes not written", cntWr, 1);
    chk(cntBcs == 3, "R7 bcs bytes included", cntBcs, 3);
    chk(cntClose == 1 && cntIrq == 1, "R7 close after crc", cntClose, 1);
    bcsTwoBytes = 0;
    clr(); sendChar(8'h03); sendChar(8'hAB); sendChar(8'h99); settle();
    chk(cntWr == 2 && cntClose == 1, "R7 one-byte lrc", cntWr, 2);

    // R8: hunt after close
    clr(); sendChar(8'h26); settle();
    chk(cntHunt == 1 && cntClose == 1, "R8 hunt pulse", cntHunt, 1);
    chk(hunting == 1, "R8 hunting level", hunting, 1);
    clr(); sendChar(8'h55); settle();
    chk(cntWr == 0 && cntBcs == 0, "R8 ignored while hunting", cntWr, 0);
    pulseResync();
    clr(); sendChar(8'h55); settle();
    chk(cntWr == 1 && hunting == 0, "R8 resync resumes", cntWr, 1);
    bcsTwoBytes = 1;
    clr(); sendChar(8'h1F); sendChar(8'hAB); settle();
    chk(cntHunt == 0, "R8 no hunt before bcs", cntHunt, 0);
    sendChar(8'hCD); settle();
    chk(cntHunt == 1 && hunting == 1, "R8 hunt after bcs", cntHunt, 1);
    pulseResync();

    // R9: invalid entry never matches
    clr(); sendChar(8'h41); sendChar(8'h77); settle();
    chk(cntWr == 2 && cntClose == 0, "R9 invalid entries", cntClose, 0);

    // mixed stream checked against the model
    alpha[0] = 8'h32; alpha[1] = 8'h10; alpha[2] = 8'h55; alpha[3] = 8'h03;
    alpha[4] = 8'h17; alpha[5] = 8'h26; alpha[6] = 8'h1F; alpha[7] = 8'h41;
    alpha[8] = 8'hAB;
    for (int n = 0; n < 400; n++) begin
      if (n % 40 == 0) transpMode = ~transpMode;
      if (n % 97 == 0) syncEn = ~syncEn;
      if (n % 61 == 0) bcsTwoBytes = ~bcsTwoBytes;
      if (hunting && ($urandom % 3 == 0)) pulseResync();
      else if ($urandom % 5 != 0) sendChar(alpha[$urandom % 9]);
      else @(negedge clk);
    end
    settle();
    finishRun();
  end

endmodule